// File: doc/BRIEF.md
# Four-Phase Parallel Byte Receiver

This block takes bytes from a slower peripheral over a byte-wide parallel link. The link uses a single active-low request line and a single acknowledge line, and every transfer goes through four phases. First the sender pulls the request line low to ask whether the receiver can take a byte. The receiver answers by raising the acknowledge line. The sender then puts the byte on the data lines and releases the request line high to mark the data as valid. The receiver takes the byte and lowers the acknowledge line to show that it has it. Once the acknowledge line is low again, the next request can begin.

The request line arrives from outside the clock domain. It passes through a synchronizer chain, and all decisions are made on the synchronized level and on its rising edge. The data lines are sampled directly, because the sender must hold them stable for as long as acknowledge is high. A captured byte is kept in a one-entry holding register. That register feeds internal logic through a valid/ready port. Acknowledge is raised only while the holding register is empty, so a slow consumer stalls the peripheral and no byte is ever lost.

Top module: `dhs_rx`

## Requirements
- R1: When `rst` is high at a clock edge, `per_ack` and `out_valid` are low after that edge, and they stay low until a new request arrives.
- R2: When `per_req_n` goes low and the holding register is empty, `per_ack` goes high after exactly SYNC_STAGES+1 rising clock edges. With the default of 2 stages, this is the third edge.
- R3: `per_ack` is never high while `out_valid` is high. A request that arrives while the holding register is full leaves `per_ack` low. `per_ack` then rises on the edge after the edge where the consumer takes the byte.
- R4: While `per_ack` is high, a rise of `per_req_n` causes a capture SYNC_STAGES+1 edges later. On that same edge `out_data` takes the value on `per_data`, `out_valid` goes high and `per_ack` goes low.
- R5: A rise of `per_req_n` while `per_ack` is low is ignored. It captures no byte, leaves `out_data` unchanged and does not raise `per_ack` later.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` do not change. `out_valid` goes low on the edge where `out_ready` is sampled high.
- R7: After `per_ack` has dropped, a new low level on `per_req_n` starts another transfer with the same timing as R2.
- R8: Changes on `per_data` after a capture have no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| per_data | input | DATA_W | Byte lines from the peripheral |
| per_req_n | input | 1 | Request line from the peripheral: low asks, rising edge marks data valid |
| per_ack | output | 1 | Acknowledge to the peripheral: high means ready, falling edge means byte taken |
| out_data | output | DATA_W | Captured byte toward internal logic |
| out_valid | output | 1 | Holding register is full |
| out_ready | input | 1 | Internal logic takes the byte |

## Verification
Each edge on `per_req_n` passes through SYNC_STAGES synchronizer flops and one state register before it shows up at the outputs. Acknowledge rising and a capture therefore both appear SYNC_STAGES+1 edges after the input changes. The holding register empties on the same edge that samples `out_ready` high. A full-to-empty change re-arms acknowledge one edge later. The bench drives inputs on the falling clock edge. For each transfer it samples once just before the due edge, where the old value must still be present, and once just after it, where the new value must be present. Stall windows are checked on every cycle, and ignored strobes are checked after a wait longer than the synchronizer latency.

// File: rtl/dhs_pkg.sv
package dhs_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } rx_state_e;
endpackage

// File: rtl/dhs_sync.sv
module dhs_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= RESET_VAL;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/dhs_fsm.sv
module dhs_fsm
  import dhs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_lvl,
  input  logic req_rise,
  input  logic hold_full,
  output logic ack,
  output logic capture
);
  rx_state_e state;
  logic      ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ack_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!req_lvl && !hold_full) begin
            state <= ST_ARMED;
            ack_q <= 1'b1;
          end
        end
        ST_ARMED: begin
          if (req_rise) begin
            state <= ST_IDLE;
            ack_q <= 1'b0;
          end
        end
        default: begin
          state <= ST_IDLE;
          ack_q <= 1'b0;
        end
      endcase
    end
  end

  assign ack     = ack_q;
  assign capture = (state == ST_ARMED) && req_rise;

  AST_ACK_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_q) && !$past(rst)) |-> !$past(hold_full)) else $error("ack raised while full"); // R3
endmodule

// File: rtl/dhs_hold.sv
module dhs_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid,
  input  logic              ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        dout  <= din;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout))) else $error("hold changed under stall"); // R6
endmodule

// File: rtl/dhs_rx.sv
module dhs_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] per_data,
  input  logic              per_req_n,
  output logic              per_ack,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic req_lvl;
  logic req_rise;
  logic capture;

  dhs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (per_req_n),
    .lvl  (req_lvl),
    .rise (req_rise)
  );

  dhs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_lvl   (req_lvl),
    .req_rise  (req_rise),
    .hold_full (out_valid),
    .ack       (per_ack),
    .capture   (capture)
  );

  dhs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (capture),
    .din   (per_data),
    .dout  (out_data),
    .valid (out_valid),
    .ready (out_ready)
  );

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !(per_ack && out_valid)) else $error("ack high with full hold"); // R3

  AST_ACK_DROP_FILLS: assert property (@(posedge clk) disable iff (rst)
    ($fell(per_ack) && !$past(rst)) |-> out_valid) else $error("ack fell without capture"); // R4

  AST_IGNORE_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (!per_ack && req_rise) |=> !$rose(out_valid)) else $error("unarmed strobe captured"); // R5
endmodule

// File: tb/tb_dhs_rx.sv
module tb_dhs_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int SYNC       = 2;
  localparam int LAT        = SYNC + 1;
  localparam int NVEC       = 6;
  // each vector: byte to send, consumer stall cycles
  localparam logic [NVEC-1:0][15:0] VEC = {
    {8'h00, 8'd0}, {8'hFF, 8'd1}, {8'h81, 8'd5},
    {8'h5A, 8'd0}, {8'hC3, 8'd2}, {8'hA5, 8'd3}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] per_data = '0;
  logic              per_req_n = 1'b1;
  logic              per_ack;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              out_ready = 1'b0;
  int                n_chk = 0;
  int                n_bad = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dhs_rx #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .per_data(per_data), .per_req_n(per_req_n),
    .per_ack(per_ack), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int stall);
    per_req_n = 1'b0;
    step(LAT - 1);
    chk("R2 R7 ack before due", {31'd0, per_ack}, 32'd0);
    step(1);
    chk("R2 R7 ack due", {31'd0, per_ack}, 32'd1);
    per_data  = b;
    per_req_n = 1'b1;
    step(LAT - 1);
    chk("R4 ack before capture", {31'd0, per_ack}, 32'd1);
    chk("R4 valid before capture", {31'd0, out_valid}, 32'd0);
    step(1);
    chk("R4 ack after capture", {31'd0, per_ack}, 32'd0);
    chk("R4 valid after capture", {31'd0, out_valid}, 32'd1);
    chk("R4 data", {24'd0, out_data}, {24'd0, b});
    per_data = ~b;
    for (int s = 0; s < stall; s++) begin
      step(1);
      chk("R6 stall valid", {31'd0, out_valid}, 32'd1);
      chk("R8 R6 stall data", {24'd0, out_data}, {24'd0, b});
    end
    out_ready = 1'b1;
    step(1);
    chk("R6 consumed", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
  endtask

  initial begin
    step(2);
    chk("R1 ack in reset", {31'd0, per_ack}, 32'd0);
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    step(4);
    chk("R1 ack idle", {31'd0, per_ack}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][15:8], int'(VEC[i][7:0]));
    end

    // fill the holding register and keep it full
    per_req_n = 1'b0;
    step(LAT);
    per_data = 8'h3C; per_req_n = 1'b1;
    step(LAT);
    chk("R4 fill", {24'd0, out_data}, 32'h3C);
    // request while full: no ack
    per_req_n = 1'b0;
    step(LAT + 3);
    chk("R3 no ack while full", {31'd0, per_ack}, 32'd0);
    out_ready = 1'b1;
    step(1);
    out_ready = 1'b0;
    chk("R3 ack low on consume edge", {31'd0, per_ack}, 32'd0);
    step(1);
    chk("R3 ack one edge after consume", {31'd0, per_ack}, 32'd1);
    per_data = 8'h66; per_req_n = 1'b1;
    step(LAT);
    chk("R4 data after stalled request", {24'd0, out_data}, 32'h66);
    // strobe cycle while full: ignored
    per_req_n = 1'b0;
    step(LAT + 1);
    per_data = 8'hFF; per_req_n = 1'b1;
    step(LAT + 2);
    chk("R5 data kept", {24'd0, out_data}, 32'h66);
    chk("R5 ack low", {31'd0, per_ack}, 32'd0);
    out_ready = 1'b1;
    step(1);
    out_ready = 1'b0;
    step(4);
    chk("R5 no late ack", {31'd0, per_ack}, 32'd0);
    chk("R5 no late capture", {31'd0, out_valid}, 32'd0);

    // reset in the middle of a transfer
    per_req_n = 1'b0;
    step(LAT);
    chk("R2 ack before reset", {31'd0, per_ack}, 32'd1);
    rst = 1'b1;
    step(1);
    chk("R1 ack cleared", {31'd0, per_ack}, 32'd0);
    chk("R1 valid cleared", {31'd0, out_valid}, 32'd0);
    per_req_n = 1'b1;
    rst = 1'b0;
    step(LAT + 2);
    chk("R1 stays idle", {31'd0, per_ack}, 32'd0);
    chk("R1 no capture", {31'd0, out_valid}, 32'd0);

    xfer(8'h17, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule